// File: doc/BRIEF.md
# Video Capture Channel Control with Self-Clearing Channel Reset

This block controls a single video capture channel. A control register carries an enable bit, a self-clearing channel-reset bit, a block-capture bit, a capture mode field and a DMA threshold field. Pixel strobes are counted once the channel is enabled. They are written into a small FIFO only when block-capture is low. A DMA engine drains the FIFO through a read port with a ready handshake. It is told to come by a one-cycle event pulse each time the fill level reaches the programmed threshold.

Software resets the channel by writing 1 to the channel-reset bit. The request crosses into the pixel-clock domain through a two-flop synchronizer. The acknowledge returns the same way, so the reset only completes while the pixel clock runs. While the reset is pending, the bit reads back as 1. During that time the FIFO and counter are held empty, the control fields sit at their defaults and no event is raised. Every DMA read is answered with ready, so a DMA engine cannot hang on the channel. Once the channel is enabled, only enable, block-capture and channel-reset can be changed. Writes to the mode and threshold fields are dropped.

Top module: `cap_chan_ctl`

## Requirements
- R1: Writing 1 to control bit 1 (address 0) starts a channel reset. The bit reads 1 until the reset finishes, and the reset finishes only while `pclk` toggles. With `pclk` stopped the bit stays 1.
- R2: `dma_evt` stays 0 in every cycle while the channel reset is pending.
- R3: `dma_ready` is 1 in every cycle while the channel reset is pending, whether or not the FIFO holds data.
- R4: After a channel reset the control register reads its default. The default is enable 0 (bit 0), block-capture 1 (bit 2), mode 0 (bits 5:4) and threshold THR_DEF (bits 15:8), which is 0x0000_0404 with the defaults. The pixel count (address 1) reads 0 and the FIFO is empty, so `dma_ready` is 0.
- R5: The channel reset clears the enable bit.
- R6: While enable is 1, a write to address 0 updates only enable and block-capture (and may start a reset). The mode and threshold fields keep their values.
- R7: The pixel count at address 1 rises by one for each `pix_valid` cycle while enable is 1, whatever block-capture holds.
- R8: `pix_data` enters the FIFO on a `pix_valid` cycle only if enable is 1 and block-capture is 0. Data leaves in arrival order, one word per cycle with `dma_rd` high and `dma_ready` high. Outside a reset, `dma_ready` is 1 exactly when the FIFO is non-empty.
- R9: `dma_evt` pulses for one cycle after the edge at which the fill level changes to a value equal to a non-zero threshold.
- R10: A strobe that arrives while the FIFO holds DEPTH words is dropped, even if a read happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0: control, 1: pixel count |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| pclk | input | 1 | Channel pixel clock, drives the reset handshake |
| pix_valid | input | 1 | Pixel strobe, bus-clock synchronous |
| pix_data | input | DATA_W | Pixel word |
| dma_rd | input | 1 | DMA read request |
| dma_ready | output | 1 | Read acknowledge |
| dma_rdata | output | DATA_W | Read data, FIFO head (0 during reset) |
| dma_evt | output | 1 | DMA service event pulse |

## Verification
The bench builds the block with DATA_W 16, DEPTH 8, CNT_W 16 and THR_DEF 4. A depth of 8 lets short directed bursts fill the FIFO, so the drop-on-full path and a threshold equal to the full level are both reached. Random thresholds from 0 to 8 then cover every level at which an event can fire, including the disabled value 0. The pixel clock runs at a period unrelated to the bus clock and can be stopped. This lets the bench hold a reset pending for many bus cycles, issue DMA reads against it, and then see it finish once the clock is running again.

// File: rtl/cap_pkg.sv
package cap_pkg;

    localparam int MODE_W = 2;
    localparam int THR_W  = 8;

    typedef struct packed {
        logic              en;
        logic              blk;
        logic [MODE_W-1:0] mode;
        logic [THR_W-1:0]  thr;
    } ctl_t;

endpackage

// File: rtl/cap_sync.sv
module cap_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= 2'b00;
        else        stg_q <= {stg_q[0], din};
    end

    assign dout = stg_q[1];
endmodule

// File: rtl/cap_rst_pix.sv
module cap_rst_pix (
    input  logic pclk,
    input  logic rst_n,
    input  logic req,
    output logic ack
);
    logic req_s;
    logic ack_q;

    cap_sync i_req_sync (
        .clk  (pclk),
        .rst_n(rst_n),
        .din  (req),
        .dout (req_s)
    );

    // Pixel-side step of the reset: echo the request once it is seen here.
    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= req_s;
    end

    assign ack = ack_q;
endmodule

// File: rtl/cap_fifo.sv
module cap_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [LW-1:0] lvl,
    output logic [LW-1:0] lvl_nxt,
    output logic          empty,
    output logic          full
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [LW-1:0] lvl;
    } fst_t;

    fst_t          f_d, f_q;
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        f_d = f_q;
        if (flush) begin
            f_d = '0;
        end else begin
            if (push) f_d.wp = f_q.wp + 1'b1;
            if (pop)  f_d.rp = f_q.rp + 1'b1;
            f_d.lvl = f_q.lvl + LW'(push) - LW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem_q[f_q.wp] <= wdata;
    end

    assign rdata   = mem_q[f_q.rp];
    assign lvl     = f_q.lvl;
    assign lvl_nxt = f_d.lvl;
    assign empty   = (f_q.lvl == '0);
    assign full    = (f_q.lvl == LW'(DEPTH));
endmodule

// File: rtl/cap_chan_ctl.sv
module cap_chan_ctl
    import cap_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int DEPTH   = 8,
    parameter int CNT_W   = 16,
    parameter int THR_DEF = 4,
    localparam int LW     = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              pclk,
    input  logic              pix_valid,
    input  logic [DATA_W-1:0] pix_data,
    input  logic              dma_rd,
    output logic              dma_ready,
    output logic [DATA_W-1:0] dma_rdata,
    output logic              dma_evt
);
    localparam ctl_t CTL_DEF = '{en: 1'b0, blk: 1'b1, mode: '0, thr: THR_W'(THR_DEF)};

    typedef struct packed {
        ctl_t             ctl;
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             evt;
    } st_t;

    st_t              s_d, s_q;
    logic             ack_pix, ack_s;
    logic             start, flush, push, pop;
    logic [DATA_W-1:0] f_rdata;
    logic [LW-1:0]    lvl_q, lvl_nxt;
    logic             f_empty, f_full;
    logic             busy_w, en_w;
    logic [MODE_W+THR_W-1:0] cfg_w;
    logic             unused_ok;

    assign unused_ok = ^{reg_wdata[7:6], reg_wdata[3]};

    cap_rst_pix i_rst_pix (
        .pclk (pclk),
        .rst_n(rst_n),
        .req  (s_q.busy),
        .ack  (ack_pix)
    );

    cap_sync i_ack_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ack_pix),
        .dout (ack_s)
    );

    assign start = reg_we && !reg_addr && reg_wdata[1] && !s_q.busy && !ack_s;
    assign flush = s_q.busy || start;
    assign push  = s_q.ctl.en && !s_q.ctl.blk && pix_valid && !f_full && !s_q.busy;
    assign pop   = dma_rd && !f_empty && !s_q.busy;

    cap_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) i_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .push   (push),
        .pop    (pop),
        .wdata  (pix_data),
        .rdata  (f_rdata),
        .lvl    (lvl_q),
        .lvl_nxt(lvl_nxt),
        .empty  (f_empty),
        .full   (f_full)
    );

    always_comb begin
        s_d     = s_q;
        s_d.evt = 1'b0;
        if (s_q.busy) begin
            if (ack_s) s_d.busy = 1'b0;
        end else if (start) begin
            s_d.busy = 1'b1;
            s_d.ctl  = CTL_DEF;
            s_d.cnt  = '0;
        end else begin
            if (reg_we && !reg_addr) begin
                s_d.ctl.en  = reg_wdata[0];
                s_d.ctl.blk = reg_wdata[2];
                if (!s_q.ctl.en) begin
                    s_d.ctl.mode = reg_wdata[5:4];
                    s_d.ctl.thr  = reg_wdata[15:8];
                end
            end
            if (s_q.ctl.en && pix_valid) s_d.cnt = s_q.cnt + 1'b1;
            s_d.evt = (s_q.ctl.thr != '0) && (lvl_nxt != lvl_q)
                   && (32'(lvl_nxt) == 32'(s_q.ctl.thr));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ctl: CTL_DEF, busy: 1'b0, cnt: '0, evt: 1'b0};
        else        s_q <= s_d;
    end

    always_comb begin
        if (reg_addr) reg_rdata = 32'(s_q.cnt);
        else reg_rdata = {16'h0, s_q.ctl.thr, 2'b00, s_q.ctl.mode, 1'b0,
                          s_q.ctl.blk, s_q.busy, s_q.ctl.en};
    end

    assign dma_ready = s_q.busy || !f_empty;
    assign dma_rdata = s_q.busy ? '0 : f_rdata;
    assign dma_evt   = s_q.evt;

    assign busy_w = s_q.busy;
    assign en_w   = s_q.ctl.en;
    assign cfg_w  = {s_q.ctl.mode, s_q.ctl.thr};
endmodule

// File: rtl/cap_chan_ctl_chk.sv
module cap_chan_ctl_chk #(
    parameter int DEPTH = 8,
    parameter int LW    = 4,
    parameter int CW    = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          en,
    input logic          ack_s,
    input logic [LW-1:0] lvl,
    input logic [CW-1:0] cfg,
    input logic          dma_ready,
    input logic          dma_evt
);
    // R1
    rst_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(ack_s));
    // R2
    rst_noevt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !dma_evt);
    // R3
    rst_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> dma_ready);
    // R5
    rst_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !en);
    // R6
    cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !busy) |=> (busy || $stable(cfg)));
    // R10
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(lvl) <= DEPTH);
endmodule

bind cap_chan_ctl cap_chan_ctl_chk #(.DEPTH(DEPTH), .LW(LW), .CW(cap_pkg::MODE_W + cap_pkg::THR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy_w),
    .en       (en_w),
    .ack_s    (ack_s),
    .lvl      (lvl_q),
    .cfg      (cfg_w),
    .dma_ready(dma_ready),
    .dma_evt  (dma_evt)
);

// File: tb/test_cap_chan_ctl.sv
`timescale 1ns/1ps
module test_cap_chan_ctl;
    localparam int DW = 16;
    localparam int DEPTH = 8;

    logic clk = 0, pclk = 0, pclk_run = 1, rst_n = 0;
    logic reg_we = 0, reg_addr = 0;
    logic [15:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic pix_valid = 0, dma_rd = 0, dma_ready, dma_evt;
    logic [DW-1:0] pix_data = 0, dma_rdata;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    logic m_en = 0, m_blk = 1, m_evt = 0;
    logic [1:0] m_mode = 0;
    logic [7:0] m_thr = 4;
    logic [15:0] m_cnt = 0;
    logic [DW-1:0] mq[$];

    cap_chan_ctl #(.DATA_W(DW), .DEPTH(DEPTH), .CNT_W(16), .THR_DEF(4)) i_cap_chan_ctl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pclk(pclk),
        .pix_valid(pix_valid), .pix_data(pix_data), .dma_rd(dma_rd),
        .dma_ready(dma_ready), .dma_rdata(dma_rdata), .dma_evt(dma_evt));

    always #10 clk = ~clk;
    always #13 if (pclk_run) pclk = ~pclk;

    function automatic logic [31:0] ctl_word();
        return {16'h0, m_thr, 2'b00, m_mode, 1'b0, m_blk, 1'b0, m_en};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input logic a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        chk(reg_rdata === exp, tag, reg_rdata, exp);
        reg_addr = 0;
    endtask

    // one bus cycle, starting and ending at a falling edge
    task automatic cyc(input logic we, input logic [15:0] wd, input logic pv, input logic rd);
        logic [DW-1:0] pd;
        int old, nl;
        bit push, pop, old_en;
        pd = DW'($urandom);
        reg_we = we; reg_addr = 0; reg_wdata = wd;
        pix_valid = pv; pix_data = pd; dma_rd = rd;
        #1;
        old = mq.size();
        chk(dma_ready === (old != 0), "R8 ready", 32'(dma_ready), 32'(old != 0));
        if (rd && old != 0) chk(dma_rdata === mq[0], "R8 order", 32'(dma_rdata), 32'(mq[0]));
        push = m_en && !m_blk && pv && old < DEPTH;
        pop = rd && old != 0;
        if (m_en && pv) m_cnt++;
        if (pop) void'(mq.pop_front());
        if (push) mq.push_back(pd);
        nl = mq.size();
        m_evt = (m_thr != 0) && (nl == 32'(m_thr)) && (nl != old);
        old_en = m_en;
        if (we) begin
            m_en = wd[0]; m_blk = wd[2];
            if (!old_en) begin m_mode = wd[5:4]; m_thr = wd[15:8]; end
        end
        @(negedge clk);
        reg_we = 0; pix_valid = 0; dma_rd = 0;
        chk(dma_evt === m_evt, "R9 event", 32'(dma_evt), 32'(m_evt));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int k;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R4: state out of power-on reset
        rd_chk(0, 32'h0000_0404, "R4 ctl default");
        rd_chk(1, 32'h0, "R4 count default");
        #1; chk(dma_ready === 1'b0, "R4 empty", 32'(dma_ready), 0);

        // R6: unlocked write, then locked write
        cyc(1, 16'h0321, 0, 0);                    // thr 3, mode 2, en 1, blk 0
        rd_chk(0, ctl_word(), "R6 unlocked write");
        cyc(1, 16'h0715, 0, 0);                    // try thr 7, mode 1, blk 1
        rd_chk(0, 32'h0000_0325, "R6 locked fields");

        // R7: counting with block-capture set, FIFO untouched
        for (int i = 0; i < 5; i++) cyc(0, 0, 1, 0);
        rd_chk(1, 32'd5, "R7 count blk");
        #1; chk(dma_ready === 1'b0, "R8 blk no push", 32'(dma_ready), 0);

        // R9/R10: reconfigure thr=DEPTH, overfill, drain
        cyc(1, 16'h0004, 0, 0);
        cyc(1, 16'((DEPTH << 8) | 1), 0, 0);
        for (int i = 0; i < DEPTH + 2; i++) cyc(0, 0, 1, 0);
        chk(mq.size() == DEPTH, "R10 model full", mq.size(), DEPTH);
        cyc(0, 0, 1, 1);                           // full: push dropped, pop taken
        for (int i = 0; i < DEPTH; i++) cyc(0, 0, 0, 1);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] wd;
            wd = {8'($urandom % (DEPTH + 1)), 2'b00, 2'($urandom), 1'b0,
                  1'($urandom % 4 == 0), 1'b0, 1'($urandom % 4 != 0)};
            cyc($urandom % 20 == 0, wd, 1'($urandom), $urandom % 3 == 0);
            if (i % 100 == 99) begin
                rd_chk(1, 32'(m_cnt), "R7 count");
                rd_chk(0, ctl_word(), "R6 ctl readback");
            end
        end

        // fill some data, then reset with the pixel clock stopped
        cyc(1, 16'h0004, 0, 0);
        cyc(1, 16'h0201, 0, 0);
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0);
        pclk_run = 0;
        reg_we = 1; reg_addr = 0; reg_wdata = 16'h0002;
        @(negedge clk);
        reg_we = 0;
        for (int i = 0; i < 40; i++) begin
            dma_rd = 1; pix_valid = 1;
            #1;
            chk(dma_ready === 1'b1, "R3 ready in reset", 32'(dma_ready), 1);
            chk(reg_rdata[1] === 1'b1, "R1 pending", 32'(reg_rdata[1]), 1);
            chk(reg_rdata[0] === 1'b0, "R5 en cleared", 32'(reg_rdata[0]), 0);
            @(negedge clk);
            chk(dma_evt === 1'b0, "R2 no event", 32'(dma_evt), 0);
        end
        pclk_run = 1;
        k = 0;
        #1;
        while (reg_rdata[1] === 1'b1 && k < 300) begin
            chk(dma_ready === 1'b1, "R3 ready in reset", 32'(dma_ready), 1);
            @(negedge clk);
            chk(dma_evt === 1'b0, "R2 no event", 32'(dma_evt), 0);
            k++;
            #1;
        end
        dma_rd = 0; pix_valid = 0;
        chk(k < 300, "R1 completes", k, 300);
        rd_chk(0, 32'h0000_0404, "R4 ctl after reset");
        rd_chk(1, 32'h0, "R4 count after reset");
        #1; chk(dma_ready === 1'b0, "R4 flushed", 32'(dma_ready), 0);
        m_en = 0; m_blk = 1; m_mode = 0; m_thr = 4; m_cnt = 0; mq.delete();

        // channel usable again after reset
        cyc(1, 16'h0201, 0, 0);
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule